// File: doc/BRIEF.md
# Banked Bit-Addressable Data RAM

This block is the 128-byte internal data store of an 8-bit controller core. One byte port reads and writes any location either by plain address or, in register mode, by a 3-bit register number that is placed into one of four eight-byte banks. The active bank is held in a small register that is loaded from the core and comes up as bank 0 after reset.

A second, single-bit port reaches a 16-byte window of 128 individually numbered bits. Through this port a bit can be set, cleared or written with a given value in one cycle, and the block does the read-modify-write inside itself. A bit read from the same port returns the numbered bit alone. Both ports can work in the same cycle. When both write the same byte, the byte write takes effect. Reads are registered and deliver the contents as they stood before any write in the same cycle.

Top module: `bitbank_ram`

## Requirements
- R1: A byte write with `reg_mode_i`=0 stores `byte_wdata_i` at `byte_addr_i` (00H..7FH). A byte read returns that byte on `byte_rdata_o` one cycle after `byte_re_i`. The output holds its value in cycles without a read.
- R2: With `reg_mode_i`=1, bits [2:0] of `byte_addr_i` are a register number n, and the access goes to byte 8*bank + n. For example, n=0 in bank 3 is 18H and n=7 in bank 3 is 1FH.
- R3: A cycle with `bank_we_i`=1 loads `bank_i` into the bank register. The new bank applies to register-mode accesses from the next cycle on. An access in the same cycle still uses the old bank.
- R4: Bit number k (0..7FH) maps to bit k[2:0] of byte 20H + k[6:3]. For example, bit 67H is bit 7 of byte 2CH. Bytes outside 20H..2FH are never changed by the bit port.
- R5: `bit_op_i` encodes the bit operation: 2'b00 none, 2'b01 set, 2'b10 clear, 2'b11 write `bit_wdata_i`. An operation changes only the addressed bit and completes in one cycle.
- R6: When a byte write and a bit operation hit the same byte in one cycle, the byte write's data is stored. When they hit different bytes, both take effect.
- R7: A read in the same cycle as a write to the same location returns the old contents.
- R8: `bit_rdata_o` returns the addressed bit one cycle after `bit_re_i` and holds its value in cycles without a bit read.
- R9: Reset sets the bank to 0 and clears both read outputs to 0. Reset does not clear the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_we_i | input | 1 | Load the bank register |
| bank_i | input | 2 | New bank number |
| byte_re_i | input | 1 | Byte read enable |
| byte_we_i | input | 1 | Byte write enable |
| reg_mode_i | input | 1 | Treat byte_addr_i[2:0] as a register number in the active bank |
| byte_addr_i | input | 7 | Byte address or register number |
| byte_wdata_i | input | 8 | Byte write data |
| bit_re_i | input | 1 | Bit read enable |
| bit_op_i | input | 2 | Bit operation: 00 none, 01 set, 10 clear, 11 write |
| bit_addr_i | input | 7 | Bit number in the bit window |
| bit_wdata_i | input | 1 | Value for the bit write operation |
| byte_rdata_o | output | 8 | Registered byte read data |
| bit_rdata_o | output | 1 | Registered bit read data |

## Verification
The bench first fills every byte with a distinct pattern and reads it back directly. This tells a correct address path apart from aliasing. It then reads and writes all eight registers in each of the four banks, including a bank load in the same cycle as an access, which separates bank remapping and its timing from plain addressing. Directed bit operations on bit 67H and on every bit of the window show whether the byte and bit numbering are correct and whether the neighbouring bits survive. Same-byte and different-byte collisions, same-cycle read-write pairs, a mid-run reset and a long random mix of both ports show the write priority, the read-before-write behaviour and the fact that the RAM contents survive reset.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
  typedef enum logic [1:0] {
    BIT_NOP = 2'b00,
    BIT_SET = 2'b01,
    BIT_CLR = 2'b10,
    BIT_PUT = 2'b11
  } bit_op_e;

  function automatic logic bit_next(input bit_op_e op, input logic cur, input logic wval);
    case (op)
      BIT_SET: return 1'b1;
      BIT_CLR: return 1'b0;
      BIT_PUT: return wval;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/bbr_bank_reg.sv
module bbr_bank_reg #(
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_o <= '0;
    else if (load_i) bank_o <= bank_i;
  end
endmodule

// File: rtl/bbr_reg_xlate.sv
module bbr_reg_xlate #(
  parameter int ADDR_W = 7,
  parameter int BANK_W = 2,
  parameter int REG_W  = 3
) (
  input  logic              reg_mode_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] phys_o
);
  logic [ADDR_W-1:0] banked;

  // bank selects the upper bits of the low register area
  assign banked = (ADDR_W'(bank_i) << REG_W) | ADDR_W'(addr_i[REG_W-1:0]);
  assign phys_o = reg_mode_i ? banked : addr_i;
endmodule

// File: rtl/bbr_bit_xlate.sv
module bbr_bit_xlate #(
  parameter int ADDR_W    = 7,
  parameter int BITADDR_W = 7,
  parameter int IDX_W     = 3,
  parameter int BIT_BASE  = 32
) (
  input  logic [BITADDR_W-1:0] bit_addr_i,
  output logic [ADDR_W-1:0]    byte_o,
  output logic [IDX_W-1:0]     idx_o
);
  assign byte_o = ADDR_W'(BIT_BASE) + ADDR_W'(bit_addr_i[BITADDR_W-1:IDX_W]);
  assign idx_o  = bit_addr_i[IDX_W-1:0];
endmodule

// File: rtl/bbr_store.sv
module bbr_store
  import bbr_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_re_i,
  input  logic              byte_we_i,
  input  logic [ADDR_W-1:0] byte_addr_i,
  input  logic [DATA_W-1:0] byte_wdata_i,
  input  logic              bit_re_i,
  input  bit_op_e           bit_op_i,
  input  logic [ADDR_W-1:0] bit_byte_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              bit_wdata_i,
  output logic [DATA_W-1:0] byte_rdata_o,
  output logic              bit_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              cur_bit;
  logic              new_bit;
  logic              bit_we;

  assign cur_bit = mem_q[bit_byte_i][bit_idx_i];
  assign new_bit = bit_next(bit_op_i, cur_bit, bit_wdata_i);
  assign bit_we  = (bit_op_i != BIT_NOP);

  // byte write wins over a bit write to the same byte
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (byte_we_i && byte_addr_i == ADDR_W'(i))
        mem_q[i] <= byte_wdata_i;
      else if (bit_we && bit_byte_i == ADDR_W'(i))
        mem_q[i][bit_idx_i] <= new_bit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_rdata_o <= '0;
      bit_rdata_o  <= 1'b0;
    end else begin
      if (byte_re_i) byte_rdata_o <= mem_q[byte_addr_i];
      if (bit_re_i)  bit_rdata_o  <= cur_bit;
    end
  end
endmodule

// File: rtl/bitbank_ram.sv
module bitbank_ram
  import bbr_pkg::*;
#(
  parameter int DEPTH     = 128,
  parameter int DATA_W    = 8,
  parameter int NUM_BANKS = 4,
  parameter int BANK_REGS = 8,
  parameter int BIT_BASE  = 32,
  parameter int BIT_BYTES = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         bank_we_i,
  input  logic [$clog2(NUM_BANKS)-1:0] bank_i,
  input  logic                         byte_re_i,
  input  logic                         byte_we_i,
  input  logic                         reg_mode_i,
  input  logic [$clog2(DEPTH)-1:0]     byte_addr_i,
  input  logic [DATA_W-1:0]            byte_wdata_i,
  input  logic                         bit_re_i,
  input  logic [1:0]                   bit_op_i,
  input  logic [$clog2(BIT_BYTES*DATA_W)-1:0] bit_addr_i,
  input  logic                         bit_wdata_i,
  output logic [DATA_W-1:0]            byte_rdata_o,
  output logic                         bit_rdata_o
);
  localparam int ADDR_W    = $clog2(DEPTH);
  localparam int BANK_W    = $clog2(NUM_BANKS);
  localparam int REG_W     = $clog2(BANK_REGS);
  localparam int IDX_W     = $clog2(DATA_W);
  localparam int BITADDR_W = $clog2(BIT_BYTES * DATA_W);

  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] phys_addr;
  logic [ADDR_W-1:0] bit_byte;
  logic [IDX_W-1:0]  bit_idx;

  bbr_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (bank_we_i),
    .bank_i (bank_i),
    .bank_o (bank_q)
  );

  bbr_reg_xlate #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .REG_W(REG_W)) u_rx (
    .reg_mode_i (reg_mode_i),
    .bank_i     (bank_q),
    .addr_i     (byte_addr_i),
    .phys_o     (phys_addr)
  );

  bbr_bit_xlate #(
    .ADDR_W(ADDR_W), .BITADDR_W(BITADDR_W), .IDX_W(IDX_W), .BIT_BASE(BIT_BASE)
  ) u_bx (
    .bit_addr_i (bit_addr_i),
    .byte_o     (bit_byte),
    .idx_o      (bit_idx)
  );

  bbr_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_re_i    (byte_re_i),
    .byte_we_i    (byte_we_i),
    .byte_addr_i  (phys_addr),
    .byte_wdata_i (byte_wdata_i),
    .bit_re_i     (bit_re_i),
    .bit_op_i     (bit_op_e'(bit_op_i)),
    .bit_byte_i   (bit_byte),
    .bit_idx_i    (bit_idx),
    .bit_wdata_i  (bit_wdata_i),
    .byte_rdata_o (byte_rdata_o),
    .bit_rdata_o  (bit_rdata_o)
  );
endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
  parameter int ADDR_W    = 7,
  parameter int BANK_W    = 2,
  parameter int DATA_W    = 8,
  parameter int BITADDR_W = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bank_we_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic [BANK_W-1:0]    bank_q,
  input logic                 byte_re_i,
  input logic                 byte_we_i,
  input logic                 reg_mode_i,
  input logic [ADDR_W-1:0]    byte_addr_i,
  input logic [DATA_W-1:0]    byte_wdata_i,
  input logic [DATA_W-1:0]    byte_rdata_o,
  input logic                 bit_re_i,
  input logic [1:0]           bit_op_i,
  input logic [BITADDR_W-1:0] bit_addr_i,
  input logic                 bit_rdata_o
);
  assert_bank_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank_we_i |=> bank_q == $past(bank_i));

  assert_bank_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_we_i |=> $stable(bank_q));

  assert_byte_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_re_i |=> $stable(byte_rdata_o));

  assert_bit_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_re_i |=> $stable(bit_rdata_o));

  assert_write_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_we_i && !reg_mode_i) ##1
    (byte_re_i && !reg_mode_i && byte_addr_i == $past(byte_addr_i) &&
     !byte_we_i && bit_op_i == 2'b00)
    |=> byte_rdata_o == $past(byte_wdata_i, 2));

  assert_bit_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_op_i == 2'b01 && !byte_we_i) ##1
    (bit_re_i && bit_addr_i == $past(bit_addr_i) && !byte_we_i && bit_op_i == 2'b00)
    |=> bit_rdata_o);
endmodule

bind bitbank_ram bbr_checker #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .BITADDR_W(BITADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bank_we_i    (bank_we_i),
  .bank_i       (bank_i),
  .bank_q       (bank_q),
  .byte_re_i    (byte_re_i),
  .byte_we_i    (byte_we_i),
  .reg_mode_i   (reg_mode_i),
  .byte_addr_i  (byte_addr_i),
  .byte_wdata_i (byte_wdata_i),
  .byte_rdata_o (byte_rdata_o),
  .bit_re_i     (bit_re_i),
  .bit_op_i     (bit_op_i),
  .bit_addr_i   (bit_addr_i),
  .bit_rdata_o  (bit_rdata_o)
);

// File: tb/bitbank_ram_test.sv
module bitbank_ram_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bank_we_i = 0;
  logic [1:0] bank_i = 0;
  logic       byte_re_i = 0, byte_we_i = 0, reg_mode_i = 0;
  logic [6:0] byte_addr_i = 0;
  logic [7:0] byte_wdata_i = 0;
  logic       bit_re_i = 0;
  logic [1:0] bit_op_i = 0;
  logic [6:0] bit_addr_i = 0;
  logic       bit_wdata_i = 0;
  logic [7:0] byte_rdata_o;
  logic       bit_rdata_o;

  int n_cmp = 0, n_bad = 0;
  int m [128];
  int bank = 0;
  int exp_byte = 0, exp_bit = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bitbank_ram uut (.*);

  task automatic idle();
    bank_we_i = 0; byte_re_i = 0; byte_we_i = 0; reg_mode_i = 0;
    bit_re_i = 0; bit_op_i = 0;
  endtask

  task automatic check(input string tag);
    n_cmp++;
    if (byte_rdata_o !== exp_byte[7:0]) begin
      n_bad++;
      $display("FAIL %s byte_rdata got %02h exp %02h", tag, byte_rdata_o, exp_byte[7:0]);
    end
    n_cmp++;
    if (bit_rdata_o !== exp_bit[0]) begin
      n_bad++;
      $display("FAIL %s bit_rdata got %b exp %b", tag, bit_rdata_o, exp_bit[0]);
    end
  endtask

  // reference model: one clock, inputs already driven
  task automatic step(input string tag);
    int pa, bb, bi, nv;
    pa = reg_mode_i ? bank * 8 + int'(byte_addr_i[2:0]) : int'(byte_addr_i);
    bb = 32 + int'(bit_addr_i) / 8;
    bi = int'(bit_addr_i) % 8;
    if (byte_re_i) exp_byte = m[pa];
    if (bit_re_i) exp_bit = (m[bb] >> bi) & 1;
    if (bit_op_i != 0) begin
      nv = (bit_op_i == 1) ? 1 : (bit_op_i == 2) ? 0 : int'(bit_wdata_i);
      m[bb] = (m[bb] & ~(1 << bi)) | (nv << bi);
    end
    if (byte_we_i) m[pa] = int'(byte_wdata_i);
    if (bank_we_i) bank = int'(bank_i);
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag);
    idle();
  endtask

  task automatic bwr(input int a, input int d, input bit rm, input string tag);
    byte_we_i = 1; reg_mode_i = rm; byte_addr_i = 7'(a); byte_wdata_i = 8'(d);
    step(tag);
  endtask

  task automatic brd(input int a, input bit rm, input string tag);
    byte_re_i = 1; reg_mode_i = rm; byte_addr_i = 7'(a);
    step(tag);
  endtask

  task automatic bitop(input int k, input int op, input bit v, input string tag);
    bit_op_i = 2'(op); bit_addr_i = 7'(k); bit_wdata_i = v;
    step(tag);
  endtask

  task automatic bitrd(input int k, input string tag);
    bit_re_i = 1; bit_addr_i = 7'(k);
    step(tag);
  endtask

  task automatic set_bank(input int b, input string tag);
    bank_we_i = 1; bank_i = 2'(b);
    step(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk_i);
    rst_ni = 0;
    bank = 0; exp_byte = 0; exp_bit = 0;
    repeat (2) @(negedge clk_i);
    check(tag);
    rst_ni = 1;
    @(negedge clk_i);
    check(tag);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    check("R9");
    rst_ni = 1;
    @(negedge clk_i);
    check("R9");

    for (int i = 0; i < 128; i++) bwr(i, (i * 37 + 5) & 8'hFF, 0, "R1");
    for (int i = 0; i < 128; i++) brd(127 - i, 0, "R1");
    repeat (3) step("R1");

    // register mode, default bank 0
    brd(5, 1, "R2");
    for (int b = 0; b < 4; b++) begin
      set_bank(b, "R3");
      for (int n = 0; n < 8; n++) brd(n, 1, "R2");
      bwr(b + 8, 8'hA0 + b, 1, "R2");
      brd(b, 0, "R2");
    end
    // bank load and register read in the same cycle: old bank applies
    bank_we_i = 1; bank_i = 2'd1; byte_re_i = 1; reg_mode_i = 1; byte_addr_i = 7'd7;
    step("R3");
    brd(7, 1, "R3");
    brd(8'h1F - 8'h10, 0, "R2");

    // bit numbering
    bwr(8'h2C, 8'h00, 0, "R4");
    bitop(8'h67, 1, 0, "R4");
    brd(8'h2C, 0, "R4");
    bitrd(8'h67, "R4");
    bitrd(8'h66, "R4");
    for (int k = 0; k < 128; k++) bitop(k, 1 + (k % 3), k[3], "R5");
    for (int k = 0; k < 128; k++) bitrd(k, "R8");
    for (int i = 16; i < 64; i++) brd(i, 0, "R4");
    for (int k = 0; k < 128; k += 9) begin
      bitop(k, 2, 0, "R5");
      brd(32 + k / 8, 0, "R5");
    end

    // collisions
    bit_op_i = 2'd1; bit_addr_i = 7'h10; byte_we_i = 1; byte_addr_i = 7'h22; byte_wdata_i = 8'h00;
    step("R6");
    brd(8'h22, 0, "R6");
    bit_op_i = 2'd1; bit_addr_i = 7'h18; byte_we_i = 1; byte_addr_i = 7'h22; byte_wdata_i = 8'h5A;
    step("R6");
    brd(8'h22, 0, "R6");
    brd(8'h23, 0, "R6");

    // same-cycle read and write
    byte_re_i = 1; byte_we_i = 1; byte_addr_i = 7'h40; byte_wdata_i = 8'hC3;
    step("R7");
    brd(8'h40, 0, "R7");
    bit_re_i = 1; bit_op_i = 2'd3; bit_addr_i = 7'h0B; bit_wdata_i = ~m[33][3];
    step("R7");
    bitrd(8'h0B, "R7");

    // reset keeps memory, clears bank and outputs
    set_bank(2, "R9");
    do_reset("R9");
    brd(3, 1, "R9");
    brd(8'h40, 0, "R9");

    // random mix
    for (int t = 0; t < 4000; t++) begin
      bank_we_i = ($urandom % 8) == 0; bank_i = 2'($urandom);
      byte_re_i = 1'($urandom); byte_we_i = 1'($urandom);
      reg_mode_i = 1'($urandom); byte_addr_i = 7'($urandom);
      if (($urandom % 2) == 0) byte_addr_i = 7'(32 + $urandom % 16);
      byte_wdata_i = 8'($urandom);
      bit_re_i = 1'($urandom); bit_op_i = 2'($urandom);
      bit_addr_i = 7'($urandom); bit_wdata_i = 1'($urandom);
      step("R6");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule